// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Register

This block is the logic core of a row driver for a large dot-matrix LCD panel. One scan pulse is clocked into a shift register and moves one position on every falling edge of the scan clock. As it moves, it selects the panel rows one after another. The register has 120 positions. It runs either as a single 120-position chain or as two independent 60-position chains. In the split form, the second chain has a scan input of its own, so two panel halves can be scanned at the same time.

A direction input sets which way the pulse travels. The same input decides which of the two bidirectional scan pins receives the pulse and which one passes it on to the next driver in a cascade. Each position is combined with the frame polarity and a blanking input to give a 2-bit drive-level code. The analog output stage uses that code to pick one of four voltage rails.

Top module: `lcd_com_scan`

## Requirements
- R1: While `rst_n` is low, all 120 register positions are held at 0. With `blank_n`=1 and `frame_pol`=0, every level code then reads 2'b10, and both scan-out pins read 0.
- R2: With `dir_fwd`=1, each falling edge of `scan_clk` loads position 1 from `pin_a_in`. Every other position p takes the old value of position p-1. In single-chain mode (`split_mode`=0), this includes position 61 taking the old value of position 60.
- R3: With `split_mode`=1 and `dir_fwd`=1, position 61 is loaded from `aux_scan_in` on each falling edge instead of from position 60.
- R4: With `dir_fwd`=0, each falling edge loads position 120 from `pin_b_in`. Every other position p takes the old value of position p+1. In single-chain mode, this includes position 60 taking the old value of position 61.
- R5: With `split_mode`=1 and `dir_fwd`=0, position 60 is loaded from `aux_scan_in` on each falling edge instead of from position 61.
- R6: With `split_mode`=0, `aux_scan_in` has no effect on the register contents.
- R7: Pin enables follow the direction.
  - With `dir_fwd`=1: `pin_b_oe`=1, `pin_a_oe`=0, and `pin_b_out` carries position 120.
  - With `dir_fwd`=0: `pin_a_oe`=1, `pin_b_oe`=0, and `pin_a_out` carries position 1.
  - An out signal whose enable is low reads 0.
- R8: Position p drives `level_code[2p-1:2p-2]`. With `blank_n`=1 the code is as follows:

  | Bit | `frame_pol` | Code |
  |-----|-------------|------|
  | 1 | 1 | 2'b11 |
  | 1 | 0 | 2'b00 |
  | 0 | 1 | 2'b01 |
  | 0 | 0 | 2'b10 |

- R9: With `blank_n`=0, every level code is 2'b11, whatever the register contents or frame polarity.
- R10: With `frame_pol`, `blank_n` and `dir_fwd` held steady, the level codes and scan-out pins change only at falling edges of `scan_clk`. They do not change at rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan shift clock, active on the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of the register |
| split_mode | input | 1 | 1: two 60-position chains, 0: one 120-position chain |
| dir_fwd | input | 1 | 1: shift toward higher positions, 0: toward lower positions |
| frame_pol | input | 1 | Frame polarity for the level mapping |
| blank_n | input | 1 | 0 forces every output to the blanking code |
| pin_a_in | input | 1 | Scan pin A input side (entry when dir_fwd=1) |
| pin_a_out | output | 1 | Scan pin A output side (position 1 when dir_fwd=0) |
| pin_a_oe | output | 1 | Scan pin A output enable |
| pin_b_in | input | 1 | Scan pin B input side (entry when dir_fwd=0) |
| pin_b_out | output | 1 | Scan pin B output side (position 120 when dir_fwd=1) |
| pin_b_oe | output | 1 | Scan pin B output enable |
| aux_scan_in | input | 1 | Scan entry for the inner end of a chain in split mode |
| level_code | output | 240 | Two-bit drive-level code per position |

## Verification
The bench builds the block with the default half length of 60. This gives the full 120-position register, so the chain seam between positions 60 and 61 sits exactly where the split mode moves it. Single pulses are walked across that seam in both directions and in both chain modes. Long random runs then mix direction, mode, frame polarity and blanking from cycle to cycle, so the seam, the two outer entries and the auxiliary entry are all exercised against a bench model of the full register.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;

    // Drive-level codes handed to the output stage
    typedef enum logic [1:0] {
        LVL_SEL_F0  = 2'b00,
        LVL_IDLE_F1 = 2'b01,
        LVL_IDLE_F0 = 2'b10,
        LVL_SEL_F1  = 2'b11
    } drive_lvl_e;

    // Blanking uses the same rail as a selected row in the high frame
    localparam drive_lvl_e LVL_BLANK = LVL_SEL_F1;

    function automatic drive_lvl_e pick_level(input logic row_on,
                                              input logic frame_hi,
                                              input logic show_n);
        drive_lvl_e lvl;
        if (!show_n)
            lvl = LVL_BLANK;
        else if (row_on)
            lvl = frame_hi ? LVL_SEL_F1 : LVL_SEL_F0;
        else
            lvl = frame_hi ? LVL_IDLE_F1 : LVL_IDLE_F0;
        return lvl;
    endfunction

endpackage

// File: rtl/lcd_scan_half.sv
// Next-value logic for one half of the scan register.
module lcd_scan_half #(
    parameter int LEN = 60
) (
    input  logic [LEN-1:0] cur,
    input  logic           fwd,
    input  logic           low_entry,
    input  logic           high_entry,
    output logic [LEN-1:0] nxt
);
    always_comb begin
        if (fwd)
            nxt = {cur[LEN-2:0], low_entry};
        else
            nxt = {high_entry, cur[LEN-1:1]};
    end
endmodule

// File: rtl/lcd_level_map.sv
// Maps every register position to its drive-level code.
module lcd_level_map
    import lcd_com_pkg::*;
#(
    parameter int NUM = 120
) (
    input  logic [NUM-1:0]   bits,
    input  logic             frame_pol,
    input  logic             blank_n,
    output logic [2*NUM-1:0] codes
);
    for (genvar i = 0; i < NUM; i++) begin : g_slot
        assign codes[2*i +: 2] = pick_level(bits[i], frame_pol, blank_n);
    end
endmodule

// File: rtl/lcd_scan_pins.sv
// Direction control of the two bidirectional scan pins.
module lcd_scan_pins (
    input  logic dir_fwd,
    input  logic first_bit,
    input  logic last_bit,
    output logic pin_a_out,
    output logic pin_a_oe,
    output logic pin_b_out,
    output logic pin_b_oe
);
    always_comb begin
        pin_a_oe  = !dir_fwd;
        pin_b_oe  = dir_fwd;
        pin_a_out = !dir_fwd & first_bit;
        pin_b_out = dir_fwd & last_bit;
    end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
    parameter int HALF_LEN = 60
) (
    input  logic                  scan_clk,
    input  logic                  rst_n,
    input  logic                  split_mode,
    input  logic                  dir_fwd,
    input  logic                  frame_pol,
    input  logic                  blank_n,
    input  logic                  pin_a_in,
    output logic                  pin_a_out,
    output logic                  pin_a_oe,
    input  logic                  pin_b_in,
    output logic                  pin_b_out,
    output logic                  pin_b_oe,
    input  logic                  aux_scan_in,
    output logic [4*HALF_LEN-1:0] level_code
);
    localparam int NUM_OUT = 2 * HALF_LEN;

    typedef struct packed {
        logic [NUM_OUT-1:0] bits;
    } scan_state_t;

    scan_state_t state_d, state_q;

    logic [HALF_LEN-1:0] lo_cur, hi_cur, lo_nxt, hi_nxt;
    logic                lo_top_entry, hi_bot_entry;

    assign lo_cur = state_q.bits[HALF_LEN-1:0];
    assign hi_cur = state_q.bits[NUM_OUT-1:HALF_LEN];

    // Seam between the halves: joined chain or auxiliary entry
    always_comb begin
        if (split_mode) begin
            lo_top_entry = aux_scan_in;
            hi_bot_entry = aux_scan_in;
        end else begin
            lo_top_entry = hi_cur[0];
            hi_bot_entry = lo_cur[HALF_LEN-1];
        end
    end

    lcd_scan_half #(.LEN(HALF_LEN)) lo_half_i (
        .cur        (lo_cur),
        .fwd        (dir_fwd),
        .low_entry  (pin_a_in),
        .high_entry (lo_top_entry),
        .nxt        (lo_nxt)
    );

    lcd_scan_half #(.LEN(HALF_LEN)) hi_half_i (
        .cur        (hi_cur),
        .fwd        (dir_fwd),
        .low_entry  (hi_bot_entry),
        .high_entry (pin_b_in),
        .nxt        (hi_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.bits = {hi_nxt, lo_nxt};
    end

    always_ff @(negedge scan_clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    lcd_scan_pins pins_i (
        .dir_fwd   (dir_fwd),
        .first_bit (state_q.bits[0]),
        .last_bit  (state_q.bits[NUM_OUT-1]),
        .pin_a_out (pin_a_out),
        .pin_a_oe  (pin_a_oe),
        .pin_b_out (pin_b_out),
        .pin_b_oe  (pin_b_oe)
    );

    lcd_level_map #(.NUM(NUM_OUT)) map_i (
        .bits      (state_q.bits),
        .frame_pol (frame_pol),
        .blank_n   (blank_n),
        .codes     (level_code)
    );
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
    parameter int HALF_LEN = 60
) (
    input logic                  scan_clk,
    input logic                  rst_n,
    input logic                  split_mode,
    input logic                  dir_fwd,
    input logic                  blank_n,
    input logic                  pin_a_in,
    input logic                  pin_b_in,
    input logic                  aux_scan_in,
    input logic                  pin_a_oe,
    input logic                  pin_b_oe,
    input logic [2*HALF_LEN-1:0] bits_q,
    input logic [4*HALF_LEN-1:0] level_code
);
    localparam int NUM = 2 * HALF_LEN;

    always @(negedge scan_clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (bits_q == '0); // R1
        end
    end

    AST_FWD_ADVANCE: assert property (@(negedge scan_clk) disable iff (!rst_n)
        dir_fwd |=> (bits_q[HALF_LEN-1:1] == $past(bits_q[HALF_LEN-2:0]))
                 && (bits_q[NUM-1:HALF_LEN+1] == $past(bits_q[NUM-2:HALF_LEN]))); // R2

    AST_FWD_ENTRY: assert property (@(negedge scan_clk) disable iff (!rst_n)
        dir_fwd |=> bits_q[0] == $past(pin_a_in)); // R2

    AST_AUX_FWD: assert property (@(negedge scan_clk) disable iff (!rst_n)
        (split_mode && dir_fwd) |=> bits_q[HALF_LEN] == $past(aux_scan_in)); // R3

    AST_REV_ENTRY: assert property (@(negedge scan_clk) disable iff (!rst_n)
        !dir_fwd |=> bits_q[NUM-1] == $past(pin_b_in)); // R4

    AST_AUX_REV: assert property (@(negedge scan_clk) disable iff (!rst_n)
        (split_mode && !dir_fwd) |=> bits_q[HALF_LEN-1] == $past(aux_scan_in)); // R5

    AST_JOIN_FWD: assert property (@(negedge scan_clk) disable iff (!rst_n)
        (!split_mode && dir_fwd) |=> bits_q[HALF_LEN] == $past(bits_q[HALF_LEN-1])); // R6

    AST_PIN_ONE_DRIVER: assert property (@(negedge scan_clk) disable iff (!rst_n)
        ($countones({pin_a_oe, pin_b_oe}) == 1) && (pin_b_oe == dir_fwd)); // R7

    AST_BLANK_ALL: assert property (@(negedge scan_clk) disable iff (!rst_n)
        !blank_n |-> level_code == '1); // R9
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.HALF_LEN(HALF_LEN)) chk_i (
    .scan_clk    (scan_clk),
    .rst_n       (rst_n),
    .split_mode  (split_mode),
    .dir_fwd     (dir_fwd),
    .blank_n     (blank_n),
    .pin_a_in    (pin_a_in),
    .pin_b_in    (pin_b_in),
    .aux_scan_in (aux_scan_in),
    .pin_a_oe    (pin_a_oe),
    .pin_b_oe    (pin_b_oe),
    .bits_q      (state_q.bits),
    .level_code  (level_code)
);

// File: tb/lcd_com_scan_tb_top.sv
module lcd_com_scan_tb_top;
    localparam int HALF = 60;
    localparam int NUM  = 2 * HALF;
    localparam int CW   = 2 * NUM;

    logic scan_clk = 1'b0;
    logic rst_n = 1'b1;
    logic split_mode = 1'b0, dir_fwd = 1'b1, frame_pol = 1'b0, blank_n = 1'b1;
    logic pin_a_in = 1'b0, pin_b_in = 1'b0, aux_scan_in = 1'b0;
    logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
    logic [CW-1:0] level_code;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [NUM-1:0] mdl = '0;
    logic [CW-1:0]  last_codes = '0;
    logic           last_a = 1'b0, last_b = 1'b0;

    always #5 scan_clk = ~scan_clk;

    lcd_com_scan #(.HALF_LEN(HALF)) dut_i (
        .scan_clk    (scan_clk),
        .rst_n       (rst_n),
        .split_mode  (split_mode),
        .dir_fwd     (dir_fwd),
        .frame_pol   (frame_pol),
        .blank_n     (blank_n),
        .pin_a_in    (pin_a_in),
        .pin_a_out   (pin_a_out),
        .pin_a_oe    (pin_a_oe),
        .pin_b_in    (pin_b_in),
        .pin_b_out   (pin_b_out),
        .pin_b_oe    (pin_b_oe),
        .aux_scan_in (aux_scan_in),
        .level_code  (level_code)
    );

    function automatic logic [CW-1:0] exp_codes(logic [NUM-1:0] b, logic fr, logic show_n);
        logic [CW-1:0] r;
        for (int i = 0; i < NUM; i++) begin
            if (!show_n)   r[2*i +: 2] = 2'b11;
            else if (b[i]) r[2*i +: 2] = fr ? 2'b11 : 2'b00;
            else           r[2*i +: 2] = fr ? 2'b01 : 2'b10;
        end
        return r;
    endfunction

    function automatic logic [NUM-1:0] shift_mdl(logic [NUM-1:0] c, logic fwd, logic spl,
                                                 logic a, logic b, logic x);
        logic [NUM-1:0] n;
        if (fwd) begin
            n = {c[NUM-2:0], a};
            if (spl) n[HALF] = x;
        end else begin
            n = {b, c[NUM-1:1]};
            if (spl) n[HALF-1] = x;
        end
        return n;
    endfunction

    task automatic check_codes(string tag, logic [CW-1:0] exp);
        checks++;
        if (level_code !== exp) begin
            failures++;
            $display("FAIL %s level_code got=%h exp=%h", tag, level_code, exp);
        end
    endtask

    task automatic check_bit(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%b exp=%b", tag, what, got, exp);
        end
    endtask

    task automatic check_pins(string tag);
        check_bit(tag, "pin_a_oe", pin_a_oe, !dir_fwd);
        check_bit(tag, "pin_b_oe", pin_b_oe, dir_fwd);
        check_bit(tag, "pin_a_out", pin_a_out, dir_fwd ? 1'b0 : mdl[0]);
        check_bit(tag, "pin_b_out", pin_b_out, dir_fwd ? mdl[NUM-1] : 1'b0);
    endtask

    // One scan-clock cycle: drive after a rising edge, check after the falling edge
    task automatic cycle(string tag, logic fwd, logic spl, logic a, logic b, logic x,
                         logic fr, logic show_n);
        logic [NUM-1:0] nxt;
        @(posedge scan_clk);
        #1;
        check_codes("R10 stable at rising edge", last_codes);
        check_bit("R10", "pin_a_out stable", pin_a_out, last_a);
        check_bit("R10", "pin_b_out stable", pin_b_out, last_b);
        dir_fwd = fwd; split_mode = spl; pin_a_in = a; pin_b_in = b;
        aux_scan_in = x; frame_pol = fr; blank_n = show_n;
        nxt = shift_mdl(mdl, fwd, spl, a, b, x);
        @(negedge scan_clk);
        #2;
        mdl = nxt;
        check_codes(tag, exp_codes(mdl, fr, show_n));
        check_pins("R7");
        last_codes = level_code;
        last_a = pin_a_out;
        last_b = pin_b_out;
    endtask

    task automatic flush(logic fwd, logic spl, int n);
        for (int i = 0; i < n; i++) cycle("R2 R4 flush", fwd, spl, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        #1 rst_n = 1'b0;
        pin_a_in = 1'b1;
        repeat (3) @(negedge scan_clk);
        #2;
        check_codes("R1 reset", exp_codes('0, 1'b0, 1'b1));
        check_bit("R1", "pin_b_out in reset", pin_b_out, 1'b0);
        dir_fwd = 1'b0;
        #1;
        check_bit("R1", "pin_a_out in reset", pin_a_out, 1'b0);
        dir_fwd = 1'b1;
        pin_a_in = 1'b0;
        last_codes = level_code; last_a = pin_a_out; last_b = pin_b_out;
        @(posedge scan_clk); #1 rst_n = 1'b1;

        // R2: single pulse across the seam in the joined chain
        cycle("R2 entry", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 2; k <= 61; k++) cycle("R2 walk", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_codes("R2 pulse at position 61", exp_codes(NUM'(1) << 60, 1'b0, 1'b1));

        // R8: mapping of the selected row and the idle rows in both frames
        cycle("R8 frame high", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check_bit("R8", "selected row code high frame", &level_code[2*61 +: 2], 1'b1);
        check_bit("R8", "idle row code high frame", level_code[1:0] == 2'b01, 1'b1);
        cycle("R8 frame low", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_bit("R8", "selected row code low frame", level_code[2*62 +: 2] == 2'b00, 1'b1);

        // R9: blanking in both frames with a pulse in the register
        cycle("R9 blank low frame", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_codes("R9 all blank", {CW{1'b1}});
        cycle("R9 blank high frame", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_codes("R9 all blank", {CW{1'b1}});

        // R6: auxiliary input held high in the joined chain has no effect
        for (int k = 0; k < NUM; k++) cycle("R6 aux ignored", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check_codes("R6 register empty", exp_codes('0, 1'b0, 1'b1));

        // R3: auxiliary entry feeds position 61 in split forward mode
        cycle("R3 aux entry", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check_codes("R3 pulse at position 61", exp_codes(NUM'(1) << 60, 1'b0, 1'b1));
        for (int k = 0; k < HALF; k++) cycle("R3 walk", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        flush(1'b1, 1'b0, NUM);

        // R4: pulse from pin B walks down across the seam in the joined chain
        cycle("R4 entry", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int k = 2; k <= 61; k++) cycle("R4 walk", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_codes("R4 pulse at position 60", exp_codes(NUM'(1) << 59, 1'b0, 1'b1));
        for (int k = 0; k < HALF; k++) cycle("R4 R7 exit at pin A", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R5: auxiliary entry feeds position 60 in split reverse mode
        cycle("R5 aux entry", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check_codes("R5 pulse at position 60", exp_codes(NUM'(1) << 59, 1'b0, 1'b1));
        cycle("R5 with pin B", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

        // Random mix of every input
        for (int k = 0; k < 4000; k++) begin
            cycle("R2 R3 R4 R5 R8 R9 random",
                  1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0),
                  1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 15) != 0));
        end
        report();
    end
endmodule